// File: doc/BRIEF.md
# Execute-Stage Timing-Error Rollback and Replay Controller

This block guards the execute stage of a small three-stage 8-bit accumulator core whose late-arriving signals are caught by error-detecting storage cells. Twenty raw error flags come in: eight on the accumulator bits, eight on the register-file write buffer and four on the ALU flags. They are ORed into one anonymous event, and the block never records which flag fired. The fetch and write stages are built shorter than execute, so only execute is monitored.

While the core runs, the block keeps a one-cycle-old copy of the program counter, the accumulator, the stack pointer and the stack entry that was last overwritten. When an error arrives, the block drops the core clock enable. One cycle later it pulses a restore strobe while its rollback buses present the saved copy. It then replays the failed instruction with a two-cycle execute window, during which the clock enable is high only in the second cycle. After that, single-cycle timing resumes. An error seen during the replay is fatal. A saturating count of completed rollbacks and a sticky fault flag form the status.

Top module: `terr_recover`

## Requirements
- R1: The merged error is the OR of all 20 flags. Bit 0 of the accumulator group, bit 0 of the register-file group and bit 3 of the ALU-flag group each start the same recovery sequence.
- R2: Synchronous active-high reset gives core_en=1, ex_stretch=0, restore_go=0, fault=0, rec_cnt=0 and zeroed rollback buses.
- R3: An error flagged in a run cycle (core_en=1, ex_stretch=0) makes core_en low in the next cycle.
- R4: restore_go is high for exactly one cycle, the second cycle after the error. The rollback buses then hold the live values of the last error-free run cycle.
- R5: The rollback buses take the live PC, accumulator, stack pointer and stack entry at each run cycle without error. They hold their values in the error cycle and throughout recovery.
- R6: ex_stretch is high for exactly two cycles, starting the cycle after restore_go. core_en is low in the first of these cycles and high in the second.
- R7: After the two stretched cycles the block is back in run: core_en=1 and ex_stretch=0.
- R8: Error flags raised in the two cycles after the error cycle (the halt cycle and the restore cycle) have no effect on the sequence.
- R9: An error during either stretched cycle sets fault. From then until reset, fault stays 1, core_en stays 0, and neither restore_go nor ex_stretch rises again.
- R10: rec_cnt rises by one per rollback, visible from the first stretched cycle, and saturates at 255.
- R11: With all flags low in run, core_en stays 1 and rec_cnt does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_acc | input | 8 | Error flags, accumulator bits |
| err_rf | input | 8 | Error flags, register-file write buffer |
| err_flg | input | 4 | Error flags, ALU flags |
| live_pc | input | 8 | Current program counter |
| live_acc | input | 8 | Current accumulator |
| live_sp | input | 4 | Current stack pointer |
| live_stk | input | 8 | Stack entry about to be overwritten |
| core_en | output | 1 | Core clock enable |
| ex_stretch | output | 1 | Execute window stretched to two cycles |
| restore_go | output | 1 | One-cycle strobe: load rollback buses into the core |
| rb_pc | output | 8 | Saved program counter |
| rb_acc | output | 8 | Saved accumulator |
| rb_sp | output | 4 | Saved stack pointer |
| rb_stk | output | 8 | Saved stack entry |
| fault | output | 1 | Sticky fatal-error flag |
| rec_cnt | output | 8 | Saturating rollback count |

## Verification
A new error and the recovery already under way can land in the same cycle. The test table raises flags in the halt and restore cycles, including all twenty flags at once. It then checks that the restore pulse, the stretch window and the counter step fall exactly where a single error puts them, and that the rollback buses still show the pre-error values. A flag raised in the second stretched cycle coincides with the one cycle in which the core is enabled during replay. Directed tests judge this case by the fault flag and by a clock enable that stays low with no further restore pulse.

// File: rtl/terr_pkg.sv
package terr_pkg;
   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_HALT    = 2'd1,
      ST_RESTORE = 2'd2,
      ST_REPLAY  = 2'd3
   } rec_state_t;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/terr_merge.sv
module terr_merge #(
   parameter int N_ACC = 8,
   parameter int N_RF  = 8,
   parameter int N_FLG = 4,
   parameter bit TREE  = 1'b1
) (
   input  logic [N_ACC-1:0] err_acc,
   input  logic [N_RF-1:0]  err_rf,
   input  logic [N_FLG-1:0] err_flg,
   output logic             err_any
);
   localparam int N_ALL = N_ACC + N_RF + N_FLG;

   initial begin
      assert (N_ACC > 0 && N_RF > 0 && N_FLG > 0)
         else $error("terr_merge: every error group needs at least one flag");
   end

   generate
      if (TREE) begin : g_tree
         logic [2:0] grp;
         assign grp[0] = |err_acc;
         assign grp[1] = |err_rf;
         assign grp[2] = |err_flg;
         assign err_any = |grp;
      end else begin : g_flat
         logic [N_ALL-1:0] all_flags;
         assign all_flags = {err_flg, err_rf, err_acc};
         assign err_any = |all_flags;
      end
   endgenerate
endmodule

// File: rtl/terr_shadow.sv
module terr_shadow #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cap,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (W > 0) else $error("terr_shadow: width must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst)      q <= '0;
      else if (cap) q <= d;
   end
endmodule

// File: rtl/terr_seq.sv
module terr_seq
   import terr_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int REPLAY_CYC = 2,
   parameter bit SATURATE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             err_any,
   output logic             core_en,
   output logic             ex_stretch,
   output logic             restore_go,
   output logic             cap_en,
   output logic             fault,
   output logic [CNT_W-1:0] rec_cnt
);
   localparam int          RC_W = cnt_bits(REPLAY_CYC);
   localparam logic [RC_W-1:0] RC_LAST = RC_W'(REPLAY_CYC - 1);

   initial begin
      assert (REPLAY_CYC >= 2) else $error("terr_seq: replay needs two or more cycles");
      assert (CNT_W > 0)       else $error("terr_seq: counter width must be positive");
   end

   rec_state_t      st, st_n;
   logic [RC_W-1:0] rc;
   logic            replay_last;

   assign replay_last = (st == ST_REPLAY) && (rc == RC_LAST);

   always_comb begin
      st_n = st;
      unique case (st)
         ST_RUN:     if (err_any) st_n = ST_HALT;
         ST_HALT:    if (!fault)  st_n = ST_RESTORE;
         ST_RESTORE: st_n = ST_REPLAY;
         ST_REPLAY: begin
            if (err_any)          st_n = ST_HALT;
            else if (replay_last) st_n = ST_RUN;
         end
         default:    st_n = ST_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= ST_RUN;
         rc    <= '0;
         fault <= 1'b0;
      end else begin
         st <= st_n;
         if (st == ST_REPLAY) rc <= rc + 1'b1;
         else                 rc <= '0;
         if (st == ST_REPLAY && err_any) fault <= 1'b1;
      end
   end

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (rst)                                   rec_cnt <= '0;
            else if (st == ST_RESTORE && !(&rec_cnt))  rec_cnt <= rec_cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst)                    rec_cnt <= '0;
            else if (st == ST_RESTORE)  rec_cnt <= rec_cnt + 1'b1;
         end
      end
   endgenerate

   assign core_en    = (st == ST_RUN) || replay_last;
   assign ex_stretch = (st == ST_REPLAY);
   assign restore_go = (st == ST_RESTORE);
   assign cap_en     = (st == ST_RUN) && !err_any;
endmodule

// File: rtl/terr_recover.sv
module terr_recover #(
   parameter int N_ACC      = 8,
   parameter int N_RF       = 8,
   parameter int N_FLG      = 4,
   parameter int PC_W       = 8,
   parameter int DATA_W     = 8,
   parameter int SP_W       = 4,
   parameter int CNT_W      = 8,
   parameter int REPLAY_CYC = 2,
   parameter bit TREE       = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_ACC-1:0]  err_acc,
   input  logic [N_RF-1:0]   err_rf,
   input  logic [N_FLG-1:0]  err_flg,
   input  logic [PC_W-1:0]   live_pc,
   input  logic [DATA_W-1:0] live_acc,
   input  logic [SP_W-1:0]   live_sp,
   input  logic [DATA_W-1:0] live_stk,
   output logic              core_en,
   output logic              ex_stretch,
   output logic              restore_go,
   output logic [PC_W-1:0]   rb_pc,
   output logic [DATA_W-1:0] rb_acc,
   output logic [SP_W-1:0]   rb_sp,
   output logic [DATA_W-1:0] rb_stk,
   output logic              fault,
   output logic [CNT_W-1:0]  rec_cnt
);
   initial begin
      assert (PC_W > 0 && DATA_W > 0 && SP_W > 0)
         else $error("terr_recover: state widths must be positive");
   end

   logic err_any;
   logic cap_en;

   terr_merge #(.N_ACC(N_ACC), .N_RF(N_RF), .N_FLG(N_FLG), .TREE(TREE)) u_merge (
      .err_acc (err_acc),
      .err_rf  (err_rf),
      .err_flg (err_flg),
      .err_any (err_any)
   );

   terr_seq #(.CNT_W(CNT_W), .REPLAY_CYC(REPLAY_CYC), .SATURATE(1'b1)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .err_any    (err_any),
      .core_en    (core_en),
      .ex_stretch (ex_stretch),
      .restore_go (restore_go),
      .cap_en     (cap_en),
      .fault      (fault),
      .rec_cnt    (rec_cnt)
   );

   terr_shadow #(.W(PC_W))   u_sh_pc  (.clk(clk), .rst(rst), .cap(cap_en), .d(live_pc),  .q(rb_pc));
   terr_shadow #(.W(DATA_W)) u_sh_acc (.clk(clk), .rst(rst), .cap(cap_en), .d(live_acc), .q(rb_acc));
   terr_shadow #(.W(SP_W))   u_sh_sp  (.clk(clk), .rst(rst), .cap(cap_en), .d(live_sp),  .q(rb_sp));
   terr_shadow #(.W(DATA_W)) u_sh_stk (.clk(clk), .rst(rst), .cap(cap_en), .d(live_stk), .q(rb_stk));
endmodule

// File: rtl/terr_recover_chk.sv
module terr_recover_chk #(
   parameter int N_ACC  = 8,
   parameter int N_RF   = 8,
   parameter int N_FLG  = 4,
   parameter int PC_W   = 8,
   parameter int DATA_W = 8,
   parameter int SP_W   = 4,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [N_ACC-1:0]  err_acc,
   input logic [N_RF-1:0]   err_rf,
   input logic [N_FLG-1:0]  err_flg,
   input logic [PC_W-1:0]   live_pc,
   input logic [DATA_W-1:0] live_acc,
   input logic [SP_W-1:0]   live_sp,
   input logic [DATA_W-1:0] live_stk,
   input logic              core_en,
   input logic              ex_stretch,
   input logic              restore_go,
   input logic [PC_W-1:0]   rb_pc,
   input logic [DATA_W-1:0] rb_acc,
   input logic [SP_W-1:0]   rb_sp,
   input logic [DATA_W-1:0] rb_stk,
   input logic              fault,
   input logic [CNT_W-1:0]  rec_cnt
);
   logic flag_seen;
   logic run_cyc;
   assign flag_seen = (|err_acc) || (|err_rf) || (|err_flg);
   assign run_cyc   = core_en && !ex_stretch;

   assert_halt_after_err_R3: assert property (@(posedge clk) disable iff (rst)
      (run_cyc && flag_seen) |=> !core_en);

   assert_restore_single_R4: assert property (@(posedge clk) disable iff (rst)
      restore_go |=> !restore_go);

   assert_restore_after_halt_R4: assert property (@(posedge clk) disable iff (rst)
      restore_go |-> (!core_en && !ex_stretch));

   assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
      (run_cyc && !flag_seen) |=> (rb_pc == $past(live_pc) && rb_acc == $past(live_acc)
                                   && rb_sp == $past(live_sp) && rb_stk == $past(live_stk)));

   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !(run_cyc && !flag_seen) |=> ($stable(rb_pc) && $stable(rb_acc)
                                    && $stable(rb_sp) && $stable(rb_stk)));

   assert_stretch_start_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(ex_stretch) |-> (!core_en && $past(restore_go)));

   assert_stretch_end_R7: assert property (@(posedge clk) disable iff (rst)
      (ex_stretch && core_en && !flag_seen) |=> (core_en && !ex_stretch));

   assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      fault |=> (fault && !core_en && !restore_go && !ex_stretch));

   assert_cnt_step_R10: assert property (@(posedge clk) disable iff (rst)
      !$stable(rec_cnt) |-> (rec_cnt == CNT_W'($past(rec_cnt) + 1'b1) && $past(restore_go)));
endmodule

bind terr_recover terr_recover_chk #(
   .N_ACC(N_ACC), .N_RF(N_RF), .N_FLG(N_FLG),
   .PC_W(PC_W), .DATA_W(DATA_W), .SP_W(SP_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst(rst), .err_acc(err_acc), .err_rf(err_rf), .err_flg(err_flg),
   .live_pc(live_pc), .live_acc(live_acc), .live_sp(live_sp), .live_stk(live_stk),
   .core_en(core_en), .ex_stretch(ex_stretch), .restore_go(restore_go),
   .rb_pc(rb_pc), .rb_acc(rb_acc), .rb_sp(rb_sp), .rb_stk(rb_stk),
   .fault(fault), .rec_cnt(rec_cnt)
);

// File: tb/sim_terr_recover.sv
module sim_terr_recover;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [19:0] errv = '0;
   logic [7:0] pc = '0;
   logic       core_en, ex_stretch, restore_go, fault;
   logic [7:0] rb_pc, rb_acc, rb_stk, rec_cnt;
   logic [3:0] rb_sp;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   terr_recover u0 (
      .clk(clk), .rst(rst),
      .err_acc(errv[7:0]), .err_rf(errv[15:8]), .err_flg(errv[19:16]),
      .live_pc(pc), .live_acc(pc ^ 8'hA5), .live_sp(pc[3:0]), .live_stk(pc + 8'h33),
      .core_en(core_en), .ex_stretch(ex_stretch), .restore_go(restore_go),
      .rb_pc(rb_pc), .rb_acc(rb_acc), .rb_sp(rb_sp), .rb_stk(rb_stk),
      .fault(fault), .rec_cnt(rec_cnt)
   );

   // row: err[46:27] pc[26:19] en[18] stretch[17] restore[16] rb_pc[15:8] cnt[7:0]
   localparam int NROW = 15;
   localparam logic [46:0] TBL [NROW] = '{
      {20'h00000, 8'h10, 1'b1, 1'b0, 1'b0, 8'h00, 8'd0},
      {20'h00000, 8'h11, 1'b1, 1'b0, 1'b0, 8'h10, 8'd0},
      {20'h00001, 8'h12, 1'b1, 1'b0, 1'b0, 8'h11, 8'd0},
      {20'h00000, 8'h13, 1'b0, 1'b0, 1'b0, 8'h11, 8'd0},
      {20'h00100, 8'h14, 1'b0, 1'b0, 1'b1, 8'h11, 8'd0},
      {20'h00000, 8'h15, 1'b0, 1'b1, 1'b0, 8'h11, 8'd1},
      {20'h00000, 8'h16, 1'b1, 1'b1, 1'b0, 8'h11, 8'd1},
      {20'h00000, 8'h17, 1'b1, 1'b0, 1'b0, 8'h11, 8'd1},
      {20'h80000, 8'h18, 1'b1, 1'b0, 1'b0, 8'h17, 8'd1},
      {20'hFFFFF, 8'h19, 1'b0, 1'b0, 1'b0, 8'h17, 8'd1},
      {20'hFFFFF, 8'h1A, 1'b0, 1'b0, 1'b1, 8'h17, 8'd1},
      {20'h00000, 8'h1B, 1'b0, 1'b1, 1'b0, 8'h17, 8'd2},
      {20'h00000, 8'h1C, 1'b1, 1'b1, 1'b0, 8'h17, 8'd2},
      {20'h00000, 8'h1D, 1'b1, 1'b0, 1'b0, 8'h17, 8'd2},
      {20'h00000, 8'h1E, 1'b1, 1'b0, 1'b0, 8'h1D, 8'd2}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      errv = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      // R2: reset state, sampled at the negedge where reset drops
      chk("R2 core_en", core_en, 1);
      chk("R2 ex_stretch", ex_stretch, 0);
      chk("R2 restore_go", restore_go, 0);
      chk("R2 fault", fault, 0);
      chk("R2 rec_cnt", rec_cnt, 0);
      chk("R2 rb_pc", rb_pc, 0);

      // table: R1 R3 R4 R5 R6 R7 R8 R10 R11
      for (int i = 0; i < NROW; i++) begin
         chk($sformatf("R3/R6/R7 core_en row %0d", i), core_en, TBL[i][18]);
         chk($sformatf("R6 ex_stretch row %0d", i), ex_stretch, TBL[i][17]);
         chk($sformatf("R4/R8 restore_go row %0d", i), restore_go, TBL[i][16]);
         chk($sformatf("R5 rb_pc row %0d", i), rb_pc, TBL[i][15:8]);
         if (TBL[i][15:8] != 8'h00) begin
            chk($sformatf("R5 rb_acc row %0d", i), rb_acc, TBL[i][15:8] ^ 8'hA5);
            chk($sformatf("R5 rb_sp row %0d", i), rb_sp, TBL[i][11:8]);
            chk($sformatf("R5 rb_stk row %0d", i), rb_stk, 8'(TBL[i][15:8] + 8'h33));
         end
         chk($sformatf("R10 rec_cnt row %0d", i), rec_cnt, TBL[i][7:0]);
         chk($sformatf("R9 fault row %0d", i), fault, 0);
         errv = TBL[i][46:27];
         pc   = TBL[i][26:19];
         @(negedge clk);
      end

      // R11: long idle run
      errv = '0;
      repeat (20) @(negedge clk);
      chk("R11 core_en idle", core_en, 1);
      chk("R11 rec_cnt idle", rec_cnt, 2);

      // R9: error in second stretched cycle is fatal
      do_reset();
      errv = 20'h00010;              // R1 accumulator group, run cycle
      @(negedge clk); errv = '0;     // halt
      @(negedge clk);                // restore
      @(negedge clk);                // replay 0
      chk("R6 stretch replay0", ex_stretch, 1);
      @(negedge clk);                // replay 1
      chk("R6 core_en replay1", core_en, 1);
      errv = 20'h01000;
      @(negedge clk); errv = 20'hFFFFF;
      chk("R9 fault set", fault, 1);
      chk("R9 core_en low", core_en, 0);
      repeat (6) @(negedge clk);
      chk("R9 fault sticky", fault, 1);
      chk("R9 core_en stays low", core_en, 0);
      chk("R9 no restore", restore_go, 0);
      chk("R9 no stretch", ex_stretch, 0);
      do_reset();
      chk("R2 fault cleared", fault, 0);
      chk("R2 core_en after fault", core_en, 1);
      chk("R2 rec_cnt cleared", rec_cnt, 0);

      // R10: saturation
      for (int k = 0; k < 260; k++) begin
         errv = (k % 2 == 0) ? 20'h40000 : 20'h00080;
         @(negedge clk); errv = '0;
         repeat (4) @(negedge clk);
         if (k == 254) chk("R10 count at 255", rec_cnt, 255);
      end
      chk("R10 saturated", rec_cnt, 255);
      chk("R7 back in run", core_en, 1);
      chk("R9 no fault after many", fault, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule